// File: doc/BRIEF.md
# Serial Display Byte Transmitter

This block sends command and data bytes to a display controller over a write-only link of four wires. The wires are an active-low select, a command/data line, a serial clock and a serial data line. A host hands over one byte at a time through a valid/ready handshake. With each byte it gives a flag that marks it as data or as a command, and a flag that marks the last byte of a burst. The block shifts each byte out most significant bit first. It derives the serial clock from the system clock through a half-period divider.

A command always travels alone in its own select window. Data bytes that are not marked last keep the window open. The serial clock then rests high and the lines hold their values until the next data byte arrives, so a burst goes out under one unbroken low select. If a command is offered while a burst is being held open, the block first closes the window. It then sends the command in a fresh window. When a window closes, all four lines go back high.

Top module: `disp_serial_tx`

## Requirements
- R1: After reset, and whenever no transfer is in progress, `lcd_cs_n`, `lcd_dc`, `lcd_sclk` and `lcd_sdata` are all 1 and `in_ready` is 1.
- R2: Each accepted byte appears on `lcd_sdata` as eight bits, most significant first. Each bit is read at a rising edge of `lcd_sclk` while `lcd_cs_n` is 0, and every window carries whole bytes only.
- R3: Let H be the effective half-period. Before every rising edge of `lcd_sclk` the clock has been low for exactly H system cycles. Rising edges within a byte are 2H cycles apart. `lcd_sdata` does not change at a rising edge.
- R4: `lcd_dc` equals the byte's data flag (1 = data, 0 = command) from the first rising edge of the byte through the eighth, and it does not change while `lcd_cs_n` stays 0.
- R5: A command byte (`in_is_data` = 0) always closes its window after one byte, whatever `in_last` is. Its window lasts 17H cycles, from the fall of `lcd_cs_n` to its rise.
- R6: After a data byte with `in_last` = 0, `lcd_cs_n` stays 0 with `lcd_sclk` high. The next data byte continues in the same window, however long the host waits.
- R7: H = `div_half`, or 1 when `div_half` is 0. It is captured when a byte is accepted, so a change of `div_half` during a byte does not alter that byte's timing.
- R8: `in_ready` is 1 only when idle, or when a burst is held open and `in_is_data` is 1. A command offered during a held burst sees `in_ready` = 0, the window is closed, and the command is sent in a new window.
- R9: After the eighth rising edge of a byte marked last, `lcd_cs_n` rises exactly 2H cycles later. `lcd_sclk` is already high at that point, and all four lines are 1 from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_half | input | DIV_W | Serial clock half-period in system cycles (0 acts as 1) |
| in_valid | input | 1 | Host offers a byte |
| in_ready | output | 1 | Block accepts the offered byte this cycle |
| in_byte | input | BYTE_W | Byte to send |
| in_is_data | input | 1 | 1 = data byte, 0 = command byte |
| in_last | input | 1 | Data byte ends the burst |
| lcd_cs_n | output | 1 | Active-low select |
| lcd_dc | output | 1 | Command/data select line |
| lcd_sclk | output | 1 | Serial clock |
| lcd_sdata | output | 1 | Serial data |

## Verification
The embedded properties watch the line discipline on every cycle. They check that data is steady at each clock rise and through each high half, that the command/data line is steady for a whole window, and that the clock is high before the select is released. They also check that the half-period counter stays in range with its latched value frozen while it runs, that a command window never holds more than one byte, and that ready is never offered while the shifter runs. Only the bench scenarios can show the exact half-period counts for every divider value, the bit order and decoded byte values across all 256 codes, and the window count of held bursts. They also show that a command interrupts a held burst, and that the 2H release and the 17H command window hold.

// File: rtl/dtx_pkg.sv
package dtx_pkg;

  typedef enum logic [1:0] {
    DTX_IDLE  = 2'd0,
    DTX_SHIFT = 2'd1,
    DTX_HOLD  = 2'd2,
    DTX_TAIL  = 2'd3
  } dtx_state_e;

  // A command always ends its window; a data byte ends it only when marked last.
  function automatic logic dtx_closes_window(input logic is_data, input logic last);
    return (!is_data) || last;
  endfunction

endpackage

// File: rtl/dtx_halfcnt.sv
module dtx_halfcnt #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_half,
  input  logic             run,
  output logic             slot_end
);

  // Effective half-period: zero is treated as one cycle.
  function automatic logic [DIV_W-1:0] eff_half(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  logic [DIV_W-1:0] half_q;
  logic [DIV_W-1:0] cnt_q;
  logic             at_limit;

  assign at_limit = (cnt_q == half_q - DIV_W'(1));
  assign slot_end = run && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= DIV_W'(1);
    end else if (load) begin
      half_q <= eff_half(div_half);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || at_limit) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  AST_CNT_BELOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < half_q)); // R7

  AST_HALF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(half_q)); // R7

endmodule

// File: rtl/dtx_bitshift.sv
module dtx_bitshift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              step,
  output logic              sdata_bit,
  output logic              phase_hi,
  output logic              byte_done
);

  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sreg_q;
  logic [IDX_W-1:0]  idx_q;
  logic              hi_q;

  assign sdata_bit = sreg_q[BYTE_W-1];
  assign phase_hi  = hi_q;
  assign byte_done = step && hi_q && (idx_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '1;
      idx_q  <= TOP_IDX;
      hi_q   <= 1'b0;
    end else if (load) begin
      sreg_q <= load_byte;
      idx_q  <= TOP_IDX;
      hi_q   <= 1'b0;
    end else if (step && !byte_done) begin
      if (!hi_q) begin
        hi_q <= 1'b1;
      end else begin
        hi_q   <= 1'b0;
        sreg_q <= {sreg_q[BYTE_W-2:0], 1'b0};
        idx_q  <= idx_q - IDX_W'(1);
      end
    end
  end

  AST_BIT_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q && $past(hi_q)) |-> $stable(sdata_bit)); // R3

endmodule

// File: rtl/dtx_seq.sv
module dtx_seq (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_is_data,
  input  logic                  in_last,
  input  logic                  slot_end,
  input  logic                  byte_done,
  output logic                  in_ready,
  output logic                  load,
  output logic                  step,
  output logic                  run,
  output logic                  dc_q,
  output dtx_pkg::dtx_state_e   state
);
  import dtx_pkg::*;

  dtx_state_e state_q, state_n;
  logic       close_q;
  logic [1:0] win_bytes_q;

  assign state = state_q;

  always_comb begin
    case (state_q)
      DTX_IDLE: in_ready = 1'b1;
      DTX_HOLD: in_ready = in_is_data;
      default:  in_ready = 1'b0;
    endcase
  end

  assign load = in_valid && in_ready;
  assign run  = (state_q == DTX_SHIFT) || (state_q == DTX_TAIL);
  assign step = (state_q == DTX_SHIFT) && slot_end;

  always_comb begin
    state_n = state_q;
    case (state_q)
      DTX_IDLE:  if (load) state_n = DTX_SHIFT;
      DTX_SHIFT: if (byte_done) state_n = close_q ? DTX_TAIL : DTX_HOLD;
      DTX_HOLD: begin
        if (load) state_n = DTX_SHIFT;
        else if (in_valid && !in_is_data) state_n = DTX_TAIL;
      end
      DTX_TAIL:  if (slot_end) state_n = DTX_IDLE;
      default:   state_n = DTX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= DTX_IDLE;
      dc_q        <= 1'b1;
      close_q     <= 1'b1;
      win_bytes_q <= 2'd0;
    end else begin
      state_q <= state_n;
      if (load) begin
        dc_q    <= in_is_data;
        close_q <= dtx_closes_window(in_is_data, in_last);
        if (state_q == DTX_IDLE) win_bytes_q <= 2'd1;
        else if (win_bytes_q != 2'd3) win_bytes_q <= win_bytes_q + 2'd1;
      end
    end
  end

  AST_CMD_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != DTX_IDLE) && !dc_q) |-> (win_bytes_q == 2'd1)); // R5

endmodule

// File: rtl/disp_serial_tx.sv
module disp_serial_tx #(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_half,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_is_data,
  input  logic              in_last,
  output logic              lcd_cs_n,
  output logic              lcd_dc,
  output logic              lcd_sclk,
  output logic              lcd_sdata
);
  import dtx_pkg::*;

  logic       load, step, run, slot_end, byte_done;
  logic       sdata_bit, phase_hi, dc_q;
  logic       line_active;
  logic       shifter_busy;
  dtx_state_e state;

  dtx_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_is_data (in_is_data),
    .in_last    (in_last),
    .slot_end   (slot_end),
    .byte_done  (byte_done),
    .in_ready   (in_ready),
    .load       (load),
    .step       (step),
    .run        (run),
    .dc_q       (dc_q),
    .state      (state)
  );

  dtx_halfcnt #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .div_half (div_half),
    .run      (run),
    .slot_end (slot_end)
  );

  dtx_bitshift #(.BYTE_W(BYTE_W)) u_shf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_byte (in_byte),
    .step      (step),
    .sdata_bit (sdata_bit),
    .phase_hi  (phase_hi),
    .byte_done (byte_done)
  );

  assign line_active  = (state != DTX_IDLE);
  assign shifter_busy = run;

  assign lcd_cs_n  = !line_active;
  assign lcd_dc    = line_active ? dc_q : 1'b1;
  assign lcd_sclk  = (state == DTX_SHIFT) ? phase_hi : 1'b1;
  assign lcd_sdata = line_active ? sdata_bit : 1'b1;

  AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !shifter_busy); // R8

  AST_SDATA_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lcd_sclk) && !lcd_cs_n) |-> $stable(lcd_sdata)); // R3

  AST_DC_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_cs_n && !$past(lcd_cs_n)) |-> $stable(lcd_dc)); // R4

  AST_CLK_HIGH_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_cs_n) |-> $past(lcd_sclk)); // R9

endmodule

// File: tb/sim_disp_serial_tx.sv
module sim_disp_serial_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_half = 8'd1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte = 8'h00;
  logic       in_is_data = 1'b0;
  logic       in_last = 1'b0;
  logic       lcd_cs_n, lcd_dc, lcd_sclk, lcd_sdata;

  always #10 clk = ~clk;

  disp_serial_tx u0 (
    .clk(clk), .rst_n(rst_n), .div_half(div_half),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .in_is_data(in_is_data), .in_last(in_last),
    .lcd_cs_n(lcd_cs_n), .lcd_dc(lcd_dc), .lcd_sclk(lcd_sclk), .lcd_sdata(lcd_sdata)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cur_h = 1;
  bit exact_tail = 1'b1;
  bit done = 1'b0;

  logic [7:0] exp_byte [0:1023];
  logic       exp_dc   [0:1023];
  int wr_idx = 0;
  int rx_idx = 0;

  int windows = 0;
  int win_start = 0;
  int win_len = 0;
  int last_fall = 0;
  int last_rise = 0;
  int last8 = 0;
  int bitcnt = 0;
  logic [7:0] shreg = 8'h00;
  logic dc_first = 1'b0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1, prev_sdata = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  // Passive line decoder
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !lcd_cs_n) begin
        windows++;
        bitcnt = 0;
        win_start = cyc;
      end
      if (!lcd_cs_n && prev_sclk && !lcd_sclk) last_fall = cyc;
      if (!lcd_cs_n && !prev_sclk && lcd_sclk) begin
        chk(cyc - last_fall == cur_h, "R3 low half length", cyc - last_fall, cur_h);
        chk(lcd_sdata == prev_sdata, "R3 data steady at rise", lcd_sdata, prev_sdata);
        if (bitcnt == 0) dc_first = lcd_dc;
        else begin
          chk(cyc - last_rise == 2 * cur_h, "R3 rise spacing", cyc - last_rise, 2 * cur_h);
          chk(lcd_dc == dc_first, "R4 dc steady in byte", lcd_dc, dc_first);
        end
        last_rise = cyc;
        shreg = {shreg[6:0], lcd_sdata};
        bitcnt++;
        if (bitcnt == 8) begin
          bitcnt = 0;
          last8 = cyc;
          if (rx_idx < wr_idx) begin
            chk(shreg == exp_byte[rx_idx], "R2 byte value", shreg, exp_byte[rx_idx]);
            chk(lcd_dc == exp_dc[rx_idx], "R4 dc at eighth rise", lcd_dc, exp_dc[rx_idx]);
          end else begin
            chk(1'b0, "R2 unexpected byte", shreg, 0);
          end
          rx_idx++;
        end
      end
      if (!prev_cs && lcd_cs_n) begin
        win_len = cyc - win_start;
        chk(bitcnt == 0, "R2 whole bytes per window", bitcnt, 0);
        if (exact_tail) chk(cyc - last8 == 2 * cur_h, "R9 release delay", cyc - last8, 2 * cur_h);
        chk({lcd_dc, lcd_sclk, lcd_sdata} == 3'b111, "R9 lines released", {lcd_dc, lcd_sclk, lcd_sdata}, 7);
      end
      prev_cs = lcd_cs_n;
      prev_sclk = lcd_sclk;
      prev_sdata = lcd_sdata;
    end
  end

  task automatic send(input logic [7:0] b, input logic isd, input logic lst);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_is_data = isd; in_last = lst;
    #1;
    if (!isd && !lcd_cs_n) chk(in_ready == 1'b0, "R8 command blocked in open window", in_ready, 0);
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    exp_byte[wr_idx] = b;
    exp_dc[wr_idx] = isd;
    wr_idx++;
    #1;
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!lcd_cs_n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_div(input int d);
    @(negedge clk);
    div_half = 8'(d);
    cur_h = (d == 0) ? 1 : d;
  endtask

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({lcd_cs_n, lcd_dc, lcd_sclk, lcd_sdata} == 4'hF, "R1 idle lines after reset",
        {lcd_cs_n, lcd_dc, lcd_sclk, lcd_sdata}, 15);
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);

    for (int d = 0; d < 6; d++) begin
      if (d == 4) continue;
      set_div(d);
      // R5: command with last=0 still closes after one byte, 17H window
      exact_tail = 1'b1;
      w0 = windows;
      send(8'(8'hC3 ^ d), 1'b0, 1'b0);
      wait_idle();
      chk(windows - w0 == 1, "R5 command window count", windows - w0, 1);
      chk(win_len == 17 * cur_h, "R5 command window length", win_len, 17 * cur_h);
      chk({lcd_cs_n, lcd_dc, lcd_sclk, lcd_sdata} == 4'hF && in_ready, "R1 idle after window",
          {lcd_cs_n, lcd_dc, lcd_sclk, lcd_sdata}, 15);

      // R6: four-byte data burst with a pause, one window
      w0 = windows;
      for (int k = 0; k < 4; k++) begin
        send(8'(k * 53 + d * 7 + 3), 1'b1, k == 3);
        if (k == 1) repeat (2 * cur_h * 8 + 6) @(negedge clk);
      end
      wait_idle();
      chk(windows - w0 == 1, "R6 burst kept in one window", windows - w0, 1);

      // R8: command offered while a burst is held open
      exact_tail = 1'b0;
      w0 = windows;
      send(8'(8'h96 + d), 1'b1, 1'b0);
      while (rx_idx != wr_idx) @(negedge clk);
      repeat (cur_h + 1) @(negedge clk);
      send(8'(8'h2B + d), 1'b0, 1'b1);
      wait_idle();
      chk(windows - w0 == 2, "R8 command moved to new window", windows - w0, 2);
      exact_tail = 1'b1;

      // R7: divider changed mid-byte does not alter the byte in flight
      send(8'(8'h5A + d), 1'b1, 1'b1);
      @(negedge clk);
      div_half = 8'(d + 3);
      wait_idle();
      chk(win_len == 17 * cur_h, "R7 latched half-period", win_len, 17 * cur_h);
      div_half = 8'(d);
    end

    // R2: all 256 byte codes in one burst at the fastest divider
    set_div(1);
    w0 = windows;
    for (int v = 0; v < 256; v++) send(8'(v), 1'b1, v == 255);
    wait_idle();
    chk(windows - w0 == 1, "R6 full code burst one window", windows - w0, 1);
    chk(rx_idx == wr_idx, "R2 all bytes received", rx_idx, wr_idx);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired: actual %0d bytes received expected %0d", rx_idx, wr_idx);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule